// File: doc/BRIEF.md
# Delayed-Difference Edge Period Filter

This block sits after an edge timestamp capture stage of an oscillator-based sensor. Each accepted sample is a timestamp of one oscillator edge, and the edges alternate between rising and falling. Every sample is written into a circular history. On the same clock edge, the block computes the span between the newest sample and a sample a fixed number of writes older. A delay of DELAY writes therefore measures DELAY/2 oscillator periods. Averaging over that window adds about log2(DELAY) exact bits to the result, so each doubling of the delay needs one more bit of value width.

A compile-time mode picks the form of the result. Edge mode returns the plain edge-to-edge span. Peak mode adds each pair of neighbouring timestamps, which follows pulse centres instead of edges. Slow offset drift on the oscillator moves its rising and falling edges in opposite directions, so the resulting duty-cycle modulation cancels in this mode. All arithmetic wraps modulo 2^VALUE_W, so a free-running timestamp counter that rolls over still gives correct spans.

Top module: `ddf_filter`

## Requirements
- R1: Each clock cycle with `wr_en` high stores `ts_in` as the newest history entry. A cycle with `wr_en` low stores nothing and does not advance the history, whatever `ts_in` carries.
- R2: `diff_out` is registered. It takes its new value at the rising edge that accepts a write and holds that value through every cycle without a write.
- R3: With MODE = DIFF_EDGE, `diff_out` equals the newest entry minus the entry written DELAY writes before it, where DELAY = 2^DELAY_LOG2.
- R4: With MODE = DIFF_PEAK, `diff_out` equals (newest + one-before-newest) minus (the entry DELAY writes before the newest + the entry DELAY+1 writes before it).
- R5: The delay is counted in accepted writes only. Any number of idle cycles between writes leaves the pairing of entries unchanged.
- R6: After reset, `diff_out` stays zero until the history holds enough entries. That is DELAY+1 writes in edge mode and DELAY+2 writes in peak mode. The first non-zero-capable result comes with that write.
- R7: Driving `rst_n` low at any time clears `diff_out` to zero and restarts both the write position and the fill count. After reset is released, R6 applies again from the beginning.
- R8: All sums and differences are taken modulo 2^VALUE_W, so timestamps that wrap past the top of the counter give the same span as unwrapped ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously by the surrounding logic |
| wr_en | input | 1 | Write strobe; high for one cycle per new timestamp |
| ts_in | input | VALUE_W | Edge timestamp, alternating rising and falling edges |
| diff_out | output | VALUE_W | Delayed span (edge or peak form), updated on each accepted write |

## Verification
The hardest condition to reach from the ports is timestamp wrap-around inside the delay window. A wrong carry or width there only shows when the newest entry has rolled past zero and the delayed entries have not. The stimulus starts a constant-step stream just below the counter top, so every result across the rollover pairs a wrapped entry with an unwrapped one. The bench checks each result against a closed-form span. A second corner is a reset in the middle of a stream, followed by a refill. It is checked together with idle gaps whose `ts_in` carries junk, which would corrupt later results if it were ever stored.

// File: rtl/ddf_pkg.sv
package ddf_pkg;
  // Output form of the delayed-difference filter
  typedef enum logic {
    DIFF_EDGE = 1'b0,  // newest minus delayed entry
    DIFF_PEAK = 1'b1   // neighbour-pair sum minus delayed neighbour-pair sum
  } diff_mode_e;
endpackage

// File: rtl/ddf_ring.sv
// Circular history of accepted samples with three read taps.
module ddf_ring #(
  parameter int VALUE_W    = 20,
  parameter int DELAY_LOG2 = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [VALUE_W-1:0] wr_data,
  output logic [VALUE_W-1:0] tap_prev,   // one write before the incoming sample
  output logic [VALUE_W-1:0] tap_old,    // DELAY writes before the incoming sample
  output logic [VALUE_W-1:0] tap_oldp    // DELAY+1 writes before the incoming sample
);
  localparam int DELAY = 1 << DELAY_LOG2;
  localparam int AW    = DELAY_LOG2 + 1;
  localparam int DEPTH = 1 << AW;

  logic [VALUE_W-1:0] mem [DEPTH];
  logic [AW-1:0]      ptr_q, ptr_d;
  logic [AW-1:0]      a_prev, a_old, a_oldp;

  // next-state
  always_comb begin
    ptr_d = ptr_q;
    if (wr_en) ptr_d = ptr_q + 1'b1;
  end

  // register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  // storage, no reset: contents before fill are masked downstream
  always_ff @(posedge clk) begin
    if (wr_en) mem[ptr_q] <= wr_data;
  end

  always_comb begin
    a_prev   = ptr_q - AW'(1);
    a_old    = ptr_q - AW'(DELAY);
    a_oldp   = ptr_q - AW'(DELAY + 1);
    tap_prev = mem[a_prev];
    tap_old  = mem[a_old];
    tap_oldp = mem[a_oldp];
  end

  // R1: position advances by exactly one per accepted write
  p_ptr_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ptr_q == AW'($past(ptr_q) + 1'b1));
  // R1: no movement without a write
  p_ptr_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(ptr_q));
endmodule

// File: rtl/ddf_fill.sv
// Counts accepted writes after reset until the history is deep enough.
module ddf_fill #(
  parameter int NEED = 65
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  output logic armed,   // the next write completes (or has completed) the fill
  output logic full     // fill complete
);
  localparam int CW = $clog2(NEED + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (wr_en && (cnt_q != CW'(NEED))) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign armed = (cnt_q >= CW'(NEED - 1));
  assign full  = (cnt_q == CW'(NEED));

  // R6: counter saturates at the fill depth
  p_fill_sat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(NEED));
  // R6: once full, stays full until reset
  p_fill_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    full |=> full);
endmodule

// File: rtl/ddf_combine.sv
// Forms the delayed span in the selected mode, modulo 2^VALUE_W.
module ddf_combine
  import ddf_pkg::*;
#(
  parameter int         VALUE_W = 20,
  parameter diff_mode_e MODE    = DIFF_EDGE
) (
  input  logic [VALUE_W-1:0] newest,
  input  logic [VALUE_W-1:0] prev,
  input  logic [VALUE_W-1:0] old,
  input  logic [VALUE_W-1:0] oldp,
  output logic [VALUE_W-1:0] span
);
  generate
    if (MODE == DIFF_PEAK) begin : g_peak
      logic [VALUE_W-1:0] sum_new, sum_old;
      always_comb begin
        sum_new = newest + prev;
        sum_old = old + oldp;
        span    = sum_new - sum_old;
      end
    end else begin : g_edge
      logic [VALUE_W-1:0] unused_pair;
      always_comb begin
        unused_pair = prev ^ oldp;
        span        = newest - old;
      end
    end
  endgenerate
endmodule

// File: rtl/ddf_filter.sv
// Delayed-difference edge period filter, top level.
module ddf_filter
  import ddf_pkg::*;
#(
  parameter int         VALUE_W    = 20,
  parameter int         DELAY_LOG2 = 6,
  parameter diff_mode_e MODE       = DIFF_EDGE
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [VALUE_W-1:0] ts_in,
  output logic [VALUE_W-1:0] diff_out
);
  localparam int DELAY = 1 << DELAY_LOG2;
  localparam int NEED  = (MODE == DIFF_PEAK) ? DELAY + 2 : DELAY + 1;

  logic [VALUE_W-1:0] tap_prev, tap_old, tap_oldp;
  logic [VALUE_W-1:0] span;
  logic [VALUE_W-1:0] out_d, out_q;
  logic               armed, full;

  ddf_ring #(.VALUE_W(VALUE_W), .DELAY_LOG2(DELAY_LOG2)) u_ring (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(ts_in),
    .tap_prev(tap_prev), .tap_old(tap_old), .tap_oldp(tap_oldp));

  ddf_fill #(.NEED(NEED)) u_fill (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .armed(armed), .full(full));

  ddf_combine #(.VALUE_W(VALUE_W), .MODE(MODE)) u_comb (
    .newest(ts_in), .prev(tap_prev), .old(tap_old), .oldp(tap_oldp),
    .span(span));

  // next-state: update only on an accepted write, zero until history is deep enough
  always_comb begin
    out_d = out_q;
    if (wr_en) out_d = armed ? span : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= '0;
    else        out_q <= out_d;
  end

  assign diff_out = out_q;

  // R2: output holds across idle cycles
  p_dout_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(diff_out));
  // R6: output stays zero while the history is still filling
  p_zero_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !full |-> diff_out == '0);
endmodule

// File: tb/ddf_filter_tb.sv
module ddf_filter_tb;
  import ddf_pkg::*;

  localparam int W  = 16;
  localparam int DL = 3;
  localparam int D  = 1 << DL;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr = 1'b0;
  logic [W-1:0] din = '0;
  logic [W-1:0] dout_e, dout_p;

  int n_chk = 0;
  int n_fail = 0;
  string cur_req = "R7";

  logic [W-1:0] hist[$];
  logic [W-1:0] exp_e[$];
  logic [W-1:0] exp_p[$];
  logic [W-1:0] last_e = '0;
  logic [W-1:0] last_p = '0;
  logic         took;
  logic [W-1:0] scr = 16'hACE1;

  always #4 clk = ~clk;  // 125 MHz

  ddf_filter #(.VALUE_W(W), .DELAY_LOG2(DL), .MODE(DIFF_EDGE)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr), .ts_in(din), .diff_out(dout_e));

  ddf_filter #(.VALUE_W(W), .DELAY_LOG2(DL), .MODE(DIFF_PEAK)) u_dut_pk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr), .ts_in(din), .diff_out(dout_p));

  task automatic check(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // reference model, R3/R6 for edge mode
  function automatic logic [W-1:0] model_edge();
    int n = hist.size();
    if (n < D + 1) return '0;
    return hist[n-1] - hist[n-1-D];
  endfunction

  // reference model, R4/R6 for peak mode
  function automatic logic [W-1:0] model_peak();
    int n = hist.size();
    if (n < D + 2) return '0;
    return hist[n-1] + hist[n-2] - hist[n-1-D] - hist[n-2-D];
  endfunction

  function automatic logic [W-1:0] next_scr(input logic [W-1:0] s);
    return {s[W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  // driver: one write, expected results queued
  task automatic push(input logic [W-1:0] v);
    @(negedge clk);
    din = v;
    wr  = 1'b1;
    hist.push_back(v);
    exp_e.push_back(model_edge());
    exp_p.push_back(model_peak());
  endtask

  // idle cycles; optional junk on ts_in (R1)
  task automatic idle(input int n, input bit junk);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wr = 1'b0;
      if (junk) begin
        scr = next_scr(scr);
        din = scr;
      end
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    wr = 1'b0;
    rst_n = 1'b0;
    hist.delete();
    exp_e.delete();
    exp_p.delete();
    last_e = '0;
    last_p = '0;
    @(negedge clk);
    check("R7 edge reset", dout_e, '0);
    check("R7 peak reset", dout_p, '0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) took <= 1'b0;
    else        took <= wr;
  end

  // monitor: result of a write is visible one cycle later (R2)
  always @(negedge clk) begin
    if (rst_n) begin
      if (took) begin
        if (exp_e.size() == 0 || exp_p.size() == 0) begin
          n_chk++;
          n_fail++;
          $display("FAIL R2: result without queued expectation, got %h/%h expected none", dout_e, dout_p);
        end else begin
          last_e = exp_e.pop_front();
          last_p = exp_p.pop_front();
          check({cur_req, " edge R3"}, dout_e, last_e);
          check({cur_req, " peak R4"}, dout_p, last_p);
        end
      end else begin
        check("R2 edge hold", dout_e, last_e);
        check("R2 peak hold", dout_p, last_p);
      end
    end
  end

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [W-1:0] t;
    repeat (2) @(negedge clk);
    // R7: reset state
    cur_req = "R7";
    do_reset();

    // R6: filling, outputs zero
    cur_req = "R6";
    for (int k = 0; k < 5; k++) push(W'(k * 37 + 3));
    idle(2, 0);

    // R3/R4: oscillator stream with varying duty
    cur_req = "R3_R4";
    do_reset();
    for (int k = 0; k < 20; k++) begin
      push(W'(k * 100));
      push(W'(k * 100 + 40 + (k % 5) * 3));
    end
    // constant duty tail
    for (int k = 20; k < 27; k++) begin
      push(W'(k * 100));
      push(W'(k * 100 + 45));
    end
    idle(2, 0);
    check("R3 directed edge span", dout_e, W'(D / 2 * 100));
    check("R4 directed peak span", dout_p, W'(D * 100));

    // R5: irregular gaps between writes
    cur_req = "R5";
    for (int k = 0; k < 30; k++) begin
      scr = next_scr(scr);
      push(scr);
      idle(1 + (k % 3), 0);
    end

    // R1: junk on ts_in while idle must not be stored
    cur_req = "R1";
    idle(10, 1);
    for (int k = 0; k < 12; k++) begin
      scr = next_scr(scr);
      push(scr);
      if (k % 4 == 0) idle(3, 1);
    end
    idle(2, 1);

    // R8: counter wrap inside the window
    cur_req = "R8";
    t = 16'hFFC0;
    for (int k = 0; k < 16; k++) begin
      push(t);
      t = t + W'(23);
    end
    idle(2, 0);
    check("R8 directed edge wrap", dout_e, W'(D * 23));
    check("R8 directed peak wrap", dout_p, W'(2 * D * 23));

    // R7/R6: reset mid-stream then refill
    cur_req = "R7";
    for (int k = 0; k < 3; k++) push(W'(k + 900));
    idle(1, 0);
    do_reset();
    cur_req = "R6";
    for (int k = 0; k < D + 2; k++) push(W'(k * 11 + 5));
    idle(2, 0);
    check("R6 edge first span", dout_e, W'((D + 1) * 11 + 5 - 16));
    check("R6 peak first span", dout_p, W'(2 * D * 11));

    // R3/R4: back-to-back pseudo-random stream
    cur_req = "R3_R4";
    for (int k = 0; k < 60; k++) begin
      scr = next_scr(scr);
      push(scr);
    end
    idle(3, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule